// File: doc/BRIEF.md
# Power Partition Gating Controller

This block switches up to thirty-two power partitions on and off and lifts the output clamps that isolate them. Software reaches it through a plain 32-bit register port with four registers. A single toggle command flips the power state of one partition, chosen by an index in the write data. A separate per-partition command releases the clamps of a partition that is already powered. Each partition carries an abstract power switch. The switch is modelled as a parameterised countdown that acknowledges when it is done. Both kinds of command report busy until that acknowledge arrives, and the busy indication then clears by itself.

Register writes complete in the cycle they are presented, and read data is a combinational view of the addressed register. The port has no back-pressure: a command that cannot be taken is dropped, following the rules below. Two partitions, set by parameters SWAP_A and SWAP_B, have their clamp-command bit positions exchanged. Software must issue a release for either of them on the other's bit.

Top module: `pwr_part_ctrl`

## Requirements
- R1: After reset every partition is unpowered and clamped. The clamp status register (offset 0x02C) reads all ones over the partition bits. The power status register (0x038), the clamp command register (0x034) and the toggle register (0x030) read zero.
- R2: Writing the toggle register (0x030) with bit 8 (START) set and a partition index in bits 4:0 starts a toggle. START reads 1 for exactly TOG_DLY cycles after the write edge. On the same edge that START clears, the addressed partition's power bit inverts. Bits 4:0 read back the last accepted index.
- R3: A toggle write with START set that arrives while a toggle is still busy is ignored. Neither the index nor any power bit changes.
- R4: Bit p of the power status register (0x038) is 1 exactly when partition p is powered.
- R5: Writing a 1 to a bit of the clamp command register (0x034) releases the clamps of the partition mapped to that bit, provided the partition is powered. The bit reads 1 for exactly CLR_DLY cycles after the write edge and then clears. On that same edge, the partition's bit in the clamp status register (0x02C) clears.
- R6: Clamp command bits SWAP_A and SWAP_B are exchanged: a 1 on bit SWAP_B releases partition SWAP_A, and the reverse. Pending state reads back on the command bit that was written. Clamp status stays indexed by the true partition number.
- R7: A clamp request for an unpowered partition is ignored and sets an error flag, read as bit 9 of the toggle register. Writing the toggle register with bit 9 set clears the flag without starting a toggle, unless START is also set.
- R8: When a toggle powers a partition off, its clamp closes again and any pending release for it is dropped. If the power-off and the release finish on the same edge, the partition ends clamped.
- R9: Reads of any offset other than the four registers return zero, and writes to them change nothing.
- R10: Only bits 4:0 of a written toggle index are used; bits 7:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | AW | Byte offset of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Combinational read data for addr |

## Verification
Two functions can finish on the same partition in the same cycle: a toggle that powers the partition off, and a clamp release that completes for it. The bench provokes this by issuing the power-off toggle and then placing the release request exactly TOG_DLY minus CLR_DLY cycles later, so both countdowns expire on one edge. The result must be an unpowered partition whose clamp status is set and whose command bit is clear. A cycle-accurate behavioural model checks every read during the approach, and directed checks with fixed expected values check the final state.

// File: rtl/pwr_part_pkg.sv
package pwr_part_pkg;
  localparam int unsigned OFS_CSTAT  = 'h02C;
  localparam int unsigned OFS_TOGGLE = 'h030;
  localparam int unsigned OFS_CCMD   = 'h034;
  localparam int unsigned OFS_PSTAT  = 'h038;
  localparam int unsigned IDX_W      = 5;
  localparam int unsigned START_BIT  = 8;
  localparam int unsigned ERR_BIT    = 9;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_TOGGLE,
    RS_CCMD,
    RS_PSTAT,
    RS_CSTAT
  } reg_sel_e;

  // Command-bit position of a partition (self-inverse exchange of a and b).
  function automatic int unsigned swap_pos(int unsigned i, int unsigned a, int unsigned b);
    return (i == a) ? b : ((i == b) ? a : i);
  endfunction
endpackage

// File: rtl/pg_delay.sv
// Countdown standing in for a power switch: busy for DLY cycles, then acknowledges.
module pg_delay #(
  parameter int unsigned DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(DLY + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(DLY);
    end else if (busy) begin
      if (done) busy <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/pg_partition.sv
// One partition: power switch, clamp-release sequencer, power and clamp state.
module pg_partition #(
  parameter int unsigned TOG_DLY = 6,
  parameter int unsigned CLR_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_start,
  input  logic clr_start,
  output logic pwr,
  output logic clamp,
  output logic tog_busy,
  output logic clr_busy
);
  logic tog_done, clr_done, going_off;

  assign going_off = tog_done && pwr;

  pg_delay #(.DLY(TOG_DLY)) u_switch (
    .clk(clk), .rst_n(rst_n), .start(tog_start), .abort(1'b0),
    .busy(tog_busy), .done(tog_done)
  );

  pg_delay #(.DLY(CLR_DLY)) u_release (
    .clk(clk), .rst_n(rst_n), .start(clr_start), .abort(going_off),
    .busy(clr_busy), .done(clr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr   <= 1'b0;
      clamp <= 1'b1;
    end else begin
      if (tog_done) pwr <= ~pwr;
      if (going_off)     clamp <= 1'b1;
      else if (clr_done) clamp <= 1'b0;
    end
  end
endmodule

// File: rtl/pg_regdec.sv
module pg_regdec #(
  parameter int unsigned AW = 12
) (
  input  logic [AW-1:0]          addr,
  output pwr_part_pkg::reg_sel_e sel
);
  import pwr_part_pkg::*;
  always_comb begin
    if      (addr == AW'(OFS_TOGGLE)) sel = RS_TOGGLE;
    else if (addr == AW'(OFS_CCMD))   sel = RS_CCMD;
    else if (addr == AW'(OFS_PSTAT))  sel = RS_PSTAT;
    else if (addr == AW'(OFS_CSTAT))  sel = RS_CSTAT;
    else                              sel = RS_NONE;
  end
endmodule

// File: rtl/pwr_part_ctrl.sv
module pwr_part_ctrl #(
  parameter int unsigned NUM_PART = 32,
  parameter int unsigned TOG_DLY  = 6,
  parameter int unsigned CLR_DLY  = 4,
  parameter int unsigned SWAP_A   = 4,
  parameter int unsigned SWAP_B   = 9,
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  import pwr_part_pkg::*;

  reg_sel_e             sel;
  logic [NUM_PART-1:0]  pwr_vec, clamp_vec, cbusy_vec, tbusy_vec;
  logic [NUM_PART-1:0]  tog_start, clr_req, clr_start, cmd_view;
  logic [IDX_W-1:0]     wr_idx, last_idx;
  logic                 tog_any, tog_go, err_q, err_hit;
  logic                 wr_tog, wr_ccmd;

  pg_regdec #(.AW(AW)) u_dec (.addr(addr), .sel(sel));

  assign wr_tog  = wr_en && (sel == RS_TOGGLE);
  assign wr_ccmd = wr_en && (sel == RS_CCMD);
  assign wr_idx  = wdata[IDX_W-1:0];
  assign tog_any = |tbusy_vec;
  assign tog_go  = wr_tog && wdata[START_BIT] && !tog_any &&
                   (32'(wr_idx) < NUM_PART);

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    localparam int unsigned CBIT = swap_pos(p, SWAP_A, SWAP_B);
    assign tog_start[p] = tog_go && (32'(wr_idx) == p);
    assign clr_req[p]   = wr_ccmd && wdata[CBIT];
    assign clr_start[p] = clr_req[p] && pwr_vec[p] && !cbusy_vec[p];
    assign cmd_view[CBIT] = cbusy_vec[p];

    pg_partition #(.TOG_DLY(TOG_DLY), .CLR_DLY(CLR_DLY)) u_part (
      .clk(clk), .rst_n(rst_n),
      .tog_start(tog_start[p]), .clr_start(clr_start[p]),
      .pwr(pwr_vec[p]), .clamp(clamp_vec[p]),
      .tog_busy(tbusy_vec[p]), .clr_busy(cbusy_vec[p])
    );
  end

  assign err_hit = |(clr_req & ~pwr_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx <= '0;
      err_q    <= 1'b0;
    end else begin
      if (tog_go) last_idx <= wr_idx;
      if (err_hit)                          err_q <= 1'b1;
      else if (wr_tog && wdata[ERR_BIT])    err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      RS_TOGGLE: begin
        rdata[IDX_W-1:0] = last_idx;
        rdata[START_BIT] = tog_any;
        rdata[ERR_BIT]   = err_q;
      end
      RS_CCMD:  rdata[NUM_PART-1:0] = cmd_view;
      RS_PSTAT: rdata[NUM_PART-1:0] = pwr_vec;
      RS_CSTAT: rdata[NUM_PART-1:0] = clamp_vec;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwr_part_ctrl_chk.sv
module pwr_part_ctrl_chk #(
  parameter int unsigned NUM_PART = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PART-1:0] pwr,
  input logic [NUM_PART-1:0] clamp,
  input logic [NUM_PART-1:0] cbusy,
  input logic [NUM_PART-1:0] tbusy,
  input logic                tog_any
);
  // R8: an unpowered partition is always clamped
  a_r8_off_is_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pwr) & (~clamp)) == '0);

  // R5: a release is only ever pending on a powered partition
  a_r5_release_on_powered: assert property (@(posedge clk) disable iff (!rst_n)
    (cbusy & ~pwr) == '0);

  // R3: at most one toggle is in flight
  a_r3_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbusy));

  // R2: power changes by at most one partition per cycle
  a_r2_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwr ^ $past(pwr)) <= 1);

  // R2: START clearing coincides with a power flip
  a_r2_flip_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tog_any) |-> (pwr != $past(pwr)));
endmodule

bind pwr_part_ctrl pwr_part_ctrl_chk #(.NUM_PART(NUM_PART)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr(pwr_vec), .clamp(clamp_vec),
  .cbusy(cbusy_vec), .tbusy(tbusy_vec), .tog_any(tog_any)
);

// File: tb/pwr_part_ctrl_tb_top.sv
module pwr_part_ctrl_tb_top;
  localparam int TD = 6;
  localparam int CD = 4;
  localparam int SA = 4;
  localparam int SB = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwr_part_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // Behavioural reference model
  bit [31:0] m_pwr, m_clamp, m_cbusy, o_pwr, o_cb;
  int        m_ccnt [32];
  bit        m_tbusy, m_err, o_tb;
  int        m_tcnt, m_tgt, m_idx, off;

  function automatic int sw(int i);
    if (i == SA) return SB;
    if (i == SB) return SA;
    return i;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 0; m_clamp = '1; m_cbusy = 0; m_tbusy = 0; m_err = 0;
      m_tcnt = 0; m_tgt = 0; m_idx = 0;
      for (int i = 0; i < 32; i++) m_ccnt[i] = 0;
    end else begin
      o_pwr = m_pwr; o_cb = m_cbusy; o_tb = m_tbusy; off = -1;
      if (m_tbusy) begin
        m_tcnt--;
        if (m_tcnt == 0) begin
          m_tbusy = 0;
          m_pwr[m_tgt] = ~m_pwr[m_tgt];
          if (!m_pwr[m_tgt]) begin
            m_clamp[m_tgt] = 1; m_cbusy[m_tgt] = 0; off = m_tgt;
          end
        end
      end
      for (int p = 0; p < 32; p++) begin
        if (m_cbusy[p]) begin
          m_ccnt[p]--;
          if (m_ccnt[p] == 0) begin m_cbusy[p] = 0; m_clamp[p] = 0; end
        end
      end
      if (wr_en && addr == 12'h030) begin
        if (wdata[9]) m_err = 0;
        if (wdata[8] && !o_tb) begin
          m_tbusy = 1; m_tcnt = TD; m_tgt = int'(wdata[4:0]); m_idx = m_tgt;
        end
      end
      if (wr_en && addr == 12'h034) begin
        for (int h = 0; h < 32; h++) begin
          if (wdata[h]) begin
            if (!o_pwr[sw(h)]) m_err = 1;
            else if (!o_cb[sw(h)] && off != sw(h)) begin
              m_cbusy[sw(h)] = 1; m_ccnt[sw(h)] = CD;
            end
          end
        end
      end
    end
  end

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] v;
    v = 0;
    case (a)
      12'h030: begin v[4:0] = 5'(m_idx); v[8] = m_tbusy; v[9] = m_err; end
      12'h034: for (int h = 0; h < 32; h++) v[h] = m_cbusy[sw(h)];
      12'h038: v = m_pwr;
      12'h02C: v = m_clamp;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h030: return "R2";
      12'h034: return "R5";
      12'h038: return "R4";
      12'h02C: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare the read against the model.
  task automatic cyc(bit we, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    #1;
    chk(tag_of(a), rdata, m_read(a));
  endtask

  task automatic rd(logic [11:0] a);
    cyc(0, a, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) rd((i % 2) ? 12'h038 : 12'h02C);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(12'h030); chk("R1", rdata, 32'h0);
    rd(12'h038); chk("R1", rdata, 32'h0);
    rd(12'h034); chk("R1", rdata, 32'h0);
    rd(12'h02C); chk("R1", rdata, 32'hFFFF_FFFF);

    // R2/R4: power on partition 2, START busy for TD reads
    cyc(1, 12'h030, 32'h102);
    for (int i = 0; i < TD; i++) begin rd(12'h030); chk("R2", rdata, 32'h102); end
    rd(12'h030); chk("R2", rdata, 32'h002);
    rd(12'h038); chk("R4", rdata, 32'h4);

    // R3: second toggle while busy is ignored
    cyc(1, 12'h030, 32'h103);
    cyc(1, 12'h030, 32'h105);
    idle(TD + 1);
    rd(12'h030); chk("R3", rdata, 32'h003);
    rd(12'h038); chk("R3", rdata, 32'h0000_000C);

    // R10: index bits 7:5 ignored
    cyc(1, 12'h030, 32'h1E7);
    idle(TD + 1);
    rd(12'h038); chk("R10", rdata, 32'h0000_008C);

    // R5: release clamps on partition 2
    cyc(1, 12'h034, 32'h4);
    for (int i = 0; i < CD; i++) begin rd(12'h034); chk("R5", rdata, 32'h4); end
    rd(12'h034); chk("R5", rdata, 32'h0);
    rd(12'h02C); chk("R5", rdata, 32'hFFFF_FFFB);

    // R6: partition SA released through command bit SB
    cyc(1, 12'h030, 32'h100 | SA);
    idle(TD + 1);
    cyc(1, 12'h034, 32'h1 << SB);
    rd(12'h034); chk("R6", rdata, 32'h1 << SB);
    idle(CD + 1);
    rd(12'h02C); chk("R6", rdata, 32'hFFFF_FFEB);
    rd(12'h030); chk("R6", rdata & 32'h200, 32'h0);

    // R7: request on unpowered partition 11 flags error; W1C clears it
    cyc(1, 12'h034, 32'h800);
    rd(12'h034); chk("R7", rdata, 32'h0);
    rd(12'h030); chk("R7", rdata, 32'h204);
    rd(12'h02C); chk("R7", rdata, 32'hFFFF_FFEB);
    cyc(1, 12'h030, 32'h200);
    rd(12'h030); chk("R7", rdata, 32'h004);
    rd(12'h038); chk("R7", rdata, 32'h0000_009C);

    // R8: power-off of 7 and its release finish on the same edge
    cyc(1, 12'h030, 32'h107);
    for (int i = 0; i < TD - CD - 1; i++) rd(12'h038);
    cyc(1, 12'h034, 32'h80);
    idle(CD + 1);
    rd(12'h038); chk("R8", rdata, 32'h0000_001C);
    rd(12'h02C); chk("R8", rdata, 32'hFFFF_FFEB);
    rd(12'h034); chk("R8", rdata, 32'h0);
    // R8: powering 2 off closes its clamp again
    cyc(1, 12'h030, 32'h102);
    idle(TD + 1);
    rd(12'h02C); chk("R8", rdata, 32'hFFFF_FFEF);
    rd(12'h038); chk("R8", rdata, 32'h0000_0018);

    // R9: unmapped offsets
    cyc(1, 12'h040, 32'hFFFF_FFFF);
    rd(12'h040); chk("R9", rdata, 32'h0);
    rd(12'h000); chk("R9", rdata, 32'h0);
    rd(12'h038); chk("R9", rdata, 32'h0000_0018);
    rd(12'h030); chk("R9", rdata, 32'h002);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule